// File: doc/BRIEF.md
# DMA Channel Configuration Register with Run-Time Interlock

This block is the configuration register of one DMA channel. Software writes it through a byte-lane write port. It holds the transfer direction, the peripheral flow-control selection, the increment options for each side, the fixed-offset option for the peripheral side, the two data widths, circular (loop) operation and the two transfer-progress interrupt enables. The datapath reads the configuration from dedicated outputs. Software reads it back on a parallel read bus.

The register does more than latch what was written. While the channel-enable input is high, the structural fields are frozen. Only the interrupt enables still accept writes. Several cross-field rules shape the configuration the datapath sees:

- Memory-to-memory transfers never use peripheral flow control.
- Peripheral flow control disables loop operation, and double-buffer operation turns it on.
- Direct (FIFO-less) operation makes the memory width follow the peripheral width.
- Direct operation or any peripheral burst disables the fixed peripheral offset.

The side inputs (direct mode, burst setting, double-buffer mode) are captured in the cycle the channel is enabled. The captured values are held for the whole enabled period.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Field layout on the write and read buses:
  - bits [1:0] direction (00 peripheral-to-memory, 01 memory-to-peripheral, 10 memory-to-memory, 11 reserved)
  - bit 2 peripheral flow control
  - bit 3 memory increment
  - bit 4 peripheral increment
  - bit 5 fixed peripheral offset
  - bits [7:6] memory width
  - bits [9:8] peripheral width (widths: 00 8-bit, 01 16-bit, 10 32-bit, 11 reserved)
  - bit 10 loop
  - bit 11 half-transfer interrupt enable
  - bit 12 full-transfer interrupt enable
  - higher bits read 0

  Readback and the field outputs show effective values.
- R2: Bits 0 to 10 accept writes only in a cycle where chan_en is 0. This includes the cycle chan_en first rises. Otherwise the write is ignored.
- R3: Bits 11 and 12 accept writes whatever the state of chan_en.
- R4: The effective flow-control bit is 0 whenever the stored direction is 10.
- R5: While chan_en is 1 and effective flow control is 1, loop_o is 0. This rule takes priority over R6.
- R6: While chan_en is 1, flow control is 0 and the captured double-buffer mode is 1, loop_o is 1.
- R7: While chan_en is 1 and the captured direct mode is 1, mwidth_o equals pwidth_o. While chan_en is 0, the stored memory width is shown.
- R8: poff_o is 0 whenever the applicable direct mode is 1 or the applicable burst setting is not 00.
- R9: In the first cycle chan_en is 1, the live direct, burst and double-buffer inputs apply. In later cycles of the same enabled period, the values seen in that first cycle apply, whatever the inputs do.
- R10: The reserved code 11 in a direction or width field is stored and read back as written. cfg_err is 1 exactly when chan_en is 1 and the direction, the peripheral width or the effective memory width is 11.
- R11: After reset all stored fields are 0, so rd_data and every field output read 0.
- R12: wr_be[0] gates bits 7:0 and wr_be[1] gates bits 15:8. A lane that is not enabled keeps its fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| wr_be | input | DW/8 | Byte-lane enables |
| chan_en | input | 1 | Channel running |
| direct_mode | input | 1 | Direct (FIFO-less) operation selected |
| burst_mode | input | 2 | Peripheral burst setting, 00 = single |
| dbuf_mode | input | 1 | Double-buffer operation selected |
| dir_o | output | 2 | Effective direction |
| pflow_o | output | 1 | Effective peripheral flow control |
| minc_o | output | 1 | Memory increment |
| pinc_o | output | 1 | Peripheral increment |
| poff_o | output | 1 | Effective fixed peripheral offset |
| mwidth_o | output | 2 | Effective memory width |
| pwidth_o | output | 2 | Peripheral width |
| loop_o | output | 1 | Effective loop mode |
| ht_ie_o | output | 1 | Half-transfer interrupt enable |
| tc_ie_o | output | 1 | Full-transfer interrupt enable |
| rd_data | output | DW | Readback of effective configuration |
| cfg_err | output | 1 | Reserved code in use while enabled |

## Verification
The hardest condition to reach is a change of the side inputs after the channel is already running. It must be shown that loop, memory width and offset hold their values. The stimulus gets there in three steps. It writes a configuration whose forced result differs from the stored one. It then raises chan_en with the side input set, and drops that input one or more cycles later while chan_en stays high. Two further sequences raise chan_en in the same cycle as a write, and combine flow control with double-buffer mode, so the lock edge and the R5/R6 priority are both exercised.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    DIR_P2M = 2'b00,
    DIR_M2P = 2'b01,
    DIR_M2M = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  // Packed so that the LSB lines up with bit 0 of the register.
  typedef struct packed {
    logic       tc_ie;
    logic       ht_ie;
    logic       loop;
    logic [1:0] pwidth;
    logic [1:0] mwidth;
    logic       poff;
    logic       pinc;
    logic       minc;
    logic       pflow;
    logic [1:0] dir;
  } cfg_t;

  typedef struct packed {
    logic               direct;
    logic [BURST_W-1:0] burst;
    logic               dbuf;
  } mode_t;

  localparam int CFG_W = $bits(cfg_t);

  // Bits frozen while the channel runs: everything but the interrupt enables.
  localparam logic [CFG_W-1:0] LOCK_MASK = {2'b00, {(CFG_W-2){1'b1}}};

endpackage

// File: rtl/dmac_field_regs.sv
module dmac_field_regs
  import dmac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] wr_be,
  input  logic            lock,
  output cfg_t            cfg_q
);

  localparam int NB = DW / 8;

  logic [DW-1:0]    lane_mask;
  logic [CFG_W-1:0] permit;
  logic [CFG_W-1:0] cfg_nxt;
  logic             cfg_ce;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{wr_en & wr_be[b]}};
    end
  endgenerate

  always_comb begin
    permit  = lane_mask[CFG_W-1:0] & (lock ? ~LOCK_MASK : {CFG_W{1'b1}});
    cfg_nxt = (cfg_q & ~permit) | (wr_data[CFG_W-1:0] & permit);
    cfg_ce  = |permit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_ce) begin
      cfg_q <= cfg_nxt;
    end
  end

endmodule

// File: rtl/dmac_mode_snap.sv
module dmac_mode_snap
  import dmac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chan_en,
  input  mode_t mode_live,
  output mode_t mode_eff
);

  logic  en_q;
  logic  rise;
  mode_t snap_q;

  always_comb begin
    rise     = chan_en & ~en_q;
    mode_eff = (chan_en & en_q) ? snap_q : mode_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= chan_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (rise) begin
      snap_q <= mode_live;
    end
  end

endmodule

// File: rtl/dmac_override.sv
module dmac_override
  import dmac_pkg::*;
(
  input  logic  chan_en,
  input  cfg_t  cfg_raw,
  input  mode_t mode,
  output cfg_t  cfg_eff,
  output logic  cfg_err
);

  logic pflow_ok;

  always_comb begin
    cfg_eff  = cfg_raw;
    pflow_ok = cfg_raw.pflow & (dir_e'(cfg_raw.dir) != DIR_M2M);
    cfg_eff.pflow = pflow_ok;

    if (chan_en) begin
      if (pflow_ok) begin
        cfg_eff.loop = 1'b0;
      end else if (mode.dbuf) begin
        cfg_eff.loop = 1'b1;
      end
      if (mode.direct) begin
        cfg_eff.mwidth = cfg_raw.pwidth;
      end
    end

    if (mode.direct || (mode.burst != '0)) begin
      cfg_eff.poff = 1'b0;
    end

    cfg_err = chan_en & ((cfg_raw.dir == 2'b11) |
                         (cfg_raw.pwidth == 2'b11) |
                         (cfg_eff.mwidth == 2'b11));
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW/8-1:0]    wr_be,
  input  logic               chan_en,
  input  logic               direct_mode,
  input  logic [BURST_W-1:0] burst_mode,
  input  logic               dbuf_mode,
  output logic [1:0]         dir_o,
  output logic               pflow_o,
  output logic               minc_o,
  output logic               pinc_o,
  output logic               poff_o,
  output logic [1:0]         mwidth_o,
  output logic [1:0]         pwidth_o,
  output logic               loop_o,
  output logic               ht_ie_o,
  output logic               tc_ie_o,
  output logic [DW-1:0]      rd_data,
  output logic               cfg_err
);

  cfg_t  cfg_raw;
  cfg_t  cfg_eff;
  mode_t mode_live;
  mode_t mode_eff;

  assign mode_live = '{direct: direct_mode, burst: burst_mode, dbuf: dbuf_mode};

  dmac_field_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .lock    (chan_en),
    .cfg_q   (cfg_raw)
  );

  dmac_mode_snap u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .mode_live (mode_live),
    .mode_eff  (mode_eff)
  );

  dmac_override u_ovr (
    .chan_en (chan_en),
    .cfg_raw (cfg_raw),
    .mode    (mode_eff),
    .cfg_eff (cfg_eff),
    .cfg_err (cfg_err)
  );

  assign dir_o    = cfg_eff.dir;
  assign pflow_o  = cfg_eff.pflow;
  assign minc_o   = cfg_eff.minc;
  assign pinc_o   = cfg_eff.pinc;
  assign poff_o   = cfg_eff.poff;
  assign mwidth_o = cfg_eff.mwidth;
  assign pwidth_o = cfg_eff.pwidth;
  assign loop_o   = cfg_eff.loop;
  assign ht_ie_o  = cfg_eff.ht_ie;
  assign tc_ie_o  = cfg_eff.tc_ie;

  generate
    if (DW > CFG_W) begin : g_pad
      assign rd_data = {{(DW-CFG_W){1'b0}}, cfg_eff};
    end else begin : g_nopad
      assign rd_data = cfg_eff[DW-1:0];
    end
  endgenerate

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic       direct_mode,
  input logic [1:0] burst_mode,
  input logic [1:0] dir_o,
  input logic       pflow_o,
  input logic       minc_o,
  input logic       pinc_o,
  input logic       poff_o,
  input logic [1:0] mwidth_o,
  input logic [1:0] pwidth_o,
  input logic       loop_o,
  input logic       cfg_err
);

  a_r2_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en ##1 chan_en |-> $stable(dir_o) && $stable(pwidth_o) &&
                            $stable(minc_o) && $stable(pinc_o) && $stable(pflow_o));

  a_r4_no_pflow_m2m: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_o == 2'b10) |-> !pflow_o);

  a_r5_pflow_no_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && pflow_o) |-> !loop_o);

  a_r7_direct_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chan_en) && direct_mode) |-> (mwidth_o == pwidth_o));

  a_r8_burst_no_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && (burst_mode != 2'b00)) |-> !poff_o);

  a_r9_held_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en ##1 chan_en |-> $stable(loop_o) && $stable(mwidth_o) && $stable(poff_o));

  a_r10_err_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> chan_en);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .direct_mode (direct_mode),
  .burst_mode  (burst_mode),
  .dir_o       (dir_o),
  .pflow_o     (pflow_o),
  .minc_o      (minc_o),
  .pinc_o      (pinc_o),
  .poff_o      (poff_o),
  .mwidth_o    (mwidth_o),
  .pwidth_o    (pwidth_o),
  .loop_o      (loop_o),
  .cfg_err     (cfg_err)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic        chan_en = 1'b0;
  logic        direct_mode = 1'b0;
  logic [1:0]  burst_mode = '0;
  logic        dbuf_mode = 1'b0;

  logic [1:0]  dir_o, mwidth_o, pwidth_o;
  logic        pflow_o, minc_o, pinc_o, poff_o, loop_o, ht_ie_o, tc_ie_o, cfg_err;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dma_chan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .chan_en(chan_en), .direct_mode(direct_mode), .burst_mode(burst_mode),
    .dbuf_mode(dbuf_mode), .dir_o(dir_o), .pflow_o(pflow_o), .minc_o(minc_o),
    .pinc_o(pinc_o), .poff_o(poff_o), .mwidth_o(mwidth_o), .pwidth_o(pwidth_o),
    .loop_o(loop_o), .ht_ie_o(ht_ie_o), .tc_ie_o(tc_ie_o), .rd_data(rd_data),
    .cfg_err(cfg_err)
  );

  // Reference model state
  int m_dir = 0, m_pw = 0, m_mw = 0;
  bit m_pflow = 0, m_minc = 0, m_pinc = 0, m_poff = 0, m_loop = 0, m_ht = 0, m_tc = 0;
  bit m_enq = 0, s_direct = 0, s_dbuf = 0;
  int s_burst = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_pw = 0; m_mw = 0; m_pflow = 0; m_minc = 0; m_pinc = 0;
      m_poff = 0; m_loop = 0; m_ht = 0; m_tc = 0; m_enq = 0;
      s_direct = 0; s_dbuf = 0; s_burst = 0;
    end else begin
      if (wr_en) begin
        if (wr_be[0] && !chan_en) begin
          m_dir = wr_data[1:0]; m_pflow = wr_data[2]; m_minc = wr_data[3];
          m_pinc = wr_data[4]; m_poff = wr_data[5]; m_mw = wr_data[7:6];
        end
        if (wr_be[1]) begin
          if (!chan_en) begin
            m_pw = wr_data[9:8]; m_loop = wr_data[10];
          end
          m_ht = wr_data[11]; m_tc = wr_data[12];
        end
      end
      if (chan_en && !m_enq) begin
        s_direct = direct_mode; s_dbuf = dbuf_mode; s_burst = burst_mode;
      end
      m_enq = chan_en;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit held, a_direct, a_dbuf, e_pflow, e_loop, e_poff, e_err;
    int a_burst, e_mw, e_rd;
    held     = chan_en && m_enq;
    a_direct = held ? s_direct : direct_mode;
    a_dbuf   = held ? s_dbuf : dbuf_mode;
    a_burst  = held ? s_burst : int'(burst_mode);
    e_pflow  = m_pflow && (m_dir != 2);
    e_loop   = m_loop;
    if (chan_en) begin
      if (e_pflow) e_loop = 0;
      else if (a_dbuf) e_loop = 1;
    end
    e_mw   = (chan_en && a_direct) ? m_pw : m_mw;
    e_poff = m_poff && !a_direct && (a_burst == 0);
    e_err  = chan_en && (m_dir == 3 || m_pw == 3 || e_mw == 3);
    e_rd   = m_dir + (int'(e_pflow) << 2) + (int'(m_minc) << 3) + (int'(m_pinc) << 4) +
             (int'(e_poff) << 5) + (e_mw << 6) + (m_pw << 8) + (int'(e_loop) << 10) +
             (int'(m_ht) << 11) + (int'(m_tc) << 12);
    chk(dir_o, m_dir, "R2 dir");
    chk(pflow_o, e_pflow, "R4 pflow");
    chk(minc_o, m_minc, "R12 minc");
    chk(pinc_o, m_pinc, "R2 pinc");
    chk(loop_o, e_loop, "R5/R6 loop");
    chk(mwidth_o, e_mw, "R7 mwidth");
    chk(pwidth_o, m_pw, "R2 pwidth");
    chk(poff_o, e_poff, "R8 poff");
    chk(ht_ie_o, m_ht, "R3 ht_ie");
    chk(tc_ie_o, m_tc, "R3 tc_ie");
    chk(rd_data, e_rd, "R1 rd_data");
    chk(cfg_err, e_err, "R10 cfg_err");
    if (!rst_n) chk(rd_data, 0, "R11 reset");
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] be);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    tick();
    wr_en = 1'b0; wr_be = '0;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    wr(16'h1FFF, 2'b11);                 // R1 all ones, reserved dir
    tick();
    wr(16'h0006, 2'b01);                 // R4 dir=M2M with pflow
    wr(16'hFF00, 2'b10);                 // R12 upper lane only
    tick();
    wr(16'h0524, 2'b11);                 // pflow, loop stored
    dbuf_mode = 1'b1; chan_en = 1'b1;    // R5 beats R6
    tick(2);
    dbuf_mode = 1'b0; tick();
    chan_en = 1'b0; tick();
    wr(16'h0110, 2'b11);                 // pflow 0, loop 0
    dbuf_mode = 1'b1; chan_en = 1'b1;    // R6
    tick();
    dbuf_mode = 1'b0; tick(2);           // R9 held
    wr(16'h1AFF, 2'b11);                 // R2 locked, R3 ie free
    chan_en = 1'b0; tick();
    wr(16'h0180, 2'b11);                 // mw=32b pw=16b
    direct_mode = 1'b1; tick();
    chan_en = 1'b1; tick();              // R7
    direct_mode = 1'b0; tick(2);         // R9
    chan_en = 1'b0; tick();
    wr(16'h0030, 2'b11);                 // pinc+poff
    burst_mode = 2'd2; tick();           // R8
    burst_mode = 2'd0; tick();
    chan_en = 1'b1; tick();
    burst_mode = 2'd1; tick(2);          // R9 poff held
    chan_en = 1'b0; burst_mode = 2'd0; tick();
    wr(16'h00C0, 2'b11);                 // R10 reserved mw stored
    chan_en = 1'b1; tick(2);
    chan_en = 1'b0; tick();
    direct_mode = 1'b1; chan_en = 1'b1; tick(2); // forced mw clears error
    chan_en = 1'b0; direct_mode = 1'b0; tick();
    wr_en = 1'b1; wr_data = 16'h0301; wr_be = 2'b11; chan_en = 1'b1; // R2 same-cycle
    tick();
    wr_en = 1'b0; tick();
    chan_en = 1'b0; tick();
    for (int i = 0; i < 60; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h3A5B) ^ 16'h5C3;
      wr_en = v[15]; wr_data = v; wr_be = v[14:13];
      chan_en = v[3] ^ v[9];
      direct_mode = v[5]; burst_mode = v[7:6]; dbuf_mode = v[11];
      tick();
    end
    wr_en = 1'b0; chan_en = 1'b0;
    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule